// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

This block decides, for a single memory access, whether a bank of protection entries permits it. The access is described by its physical word address, its kind (instruction fetch, load, store or atomic) and the privilege level it runs at. Each entry supplies an already legalised configuration byte and an address register. The block compares the access against every entry at once, picks the governing entry and reports allow or fault. It holds no state: the decision is a pure function of its inputs.

Each entry has one of four matching modes. A disabled entry matches nothing. A range entry covers the words from the previous entry's register (zero for the first entry) up to, but not including, its own register. A single-word entry covers one aligned 4-byte word. A power-of-two entry covers an aligned region whose size follows from the count of trailing ones in its register. When several entries match, the lowest-numbered one alone decides. Machine-level accesses are checked against the permissions only when the governing entry carries its lock bit. Supervisor and user accesses are always checked, and they fault when no entry matches.

The block is used inside a core's load/store and fetch paths, beside the attribute checks and trap logic that consume its verdict. Register storage and legalisation sit outside it.

Top module: `pmp_access_checker`

## Requirements
- R1: An entry whose mode field (configuration bits 4:3) is 0 matches no address, whatever its register holds.
- R2: Mode 1 (range) matches word address w when lower <= w < upper. Upper is the entry's own register. Lower is the register of the entry one index below, or zero for entry 0. A range whose upper bound is not above its lower bound matches nothing.
- R3: Mode 2 matches only the one word whose address equals the entry's register.
- R4: Mode 3 matches an aligned region of 2^(N+3) bytes, where N is the number of trailing ones in the register; the bits above those trailing ones plus one give the base. A register of all ones matches every address.
- R5: When several entries match, only the lowest-numbered matching entry determines the verdict.
- R6: Privilege code 3 (machine) is allowed whenever the governing entry has its lock bit (configuration bit 7) clear, whatever its permissions.
- R7: When the governing entry is locked, its permissions apply to machine accesses as well.
- R8: Access kind 0 (fetch) needs X (bit 2), kind 1 (load) needs R (bit 0), kinds 2 (store) and 3 (atomic) need W (bit 1). Privilege codes 0 and 1 (user, supervisor) are always checked this way against the governing entry.
- R9: With no matching entry, a machine access is allowed and any other access faults, provided at least one entry is implemented.
- R10: Configuration bits 6:5 have no effect on the verdict.

Entry i uses bits [8i+7:8i] of the configuration bus and bits [W*i+W-1:W*i] of the address register bus, where W is the word-address width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pa_word_i | input | PA_W-2 | Physical address of the access, bits PA_W-1 down to 2 |
| acc_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 atomic |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| cfg_i | input | 8*NUM_ENTRIES | Configuration byte of every entry, entry 0 lowest |
| addr_reg_i | input | (PA_W-2)*NUM_ENTRIES | Address register of every entry, entry 0 lowest |
| allow_o | output | 1 | 1 when the access is permitted, 0 when it faults |

## Verification
The verdict is combinational, so it is due in the same cycle as the stimulus that causes it. No register lies between any input and allow_o. The bench changes the inputs just after a falling edge and samples allow_o half a low phase later, before the next rising edge. Every sample compares the result with both the expected value and a behavioural model that counts trailing ones and shifts integers. Directed cases sit on the range edges and region boundaries, and a run of random vectors exercises priority and locking together.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_ATOMIC = 2'd3
  } acc_kind_e;

  localparam logic [1:0] PRIV_MACHINE = 2'b11;

  typedef struct packed {
    logic        lock;
    logic [1:0]  rsvd;
    match_mode_e mode;
    logic        x;
    logic        w;
    logic        r;
  } entry_cfg_t;

  function automatic logic perm_for_kind(input acc_kind_e kind, input logic r,
                                         input logic w, input logic x);
    logic p;
    unique case (kind)
      ACC_FETCH: p = x;
      ACC_LOAD:  p = r;
      default:   p = w;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match
  import pmp_chk_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        mode_i,
  input  logic [WORD_W-1:0] own_reg_i,
  input  logic [WORD_W-1:0] prev_reg_i,
  output logic              match_o
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  function automatic logic [WORD_W-1:0] napot_keep_mask(input logic [WORD_W-1:0] r);
    return ~(r ^ (r + ONE));
  endfunction

  function automatic logic in_half_open(input logic [WORD_W-1:0] w,
                                        input logic [WORD_W-1:0] lo,
                                        input logic [WORD_W-1:0] hi);
    return (w >= lo) && (w < hi);
  endfunction

  match_mode_e       mode;
  logic              tor_hit;
  logic              na4_hit;
  logic              napot_hit;
  logic [WORD_W-1:0] keep_mask;

  assign mode      = match_mode_e'(mode_i);
  assign keep_mask = napot_keep_mask(own_reg_i);
  assign tor_hit   = in_half_open(word_i, prev_reg_i, own_reg_i);
  assign na4_hit   = (word_i == own_reg_i);
  assign napot_hit = ((word_i & keep_mask) == (own_reg_i & keep_mask));

  always_comb begin
    unique case (mode)
      MODE_TOR:   match_o = tor_hit;
      MODE_NA4:   match_o = na4_hit;
      MODE_NAPOT: match_o = napot_hit;
      default:    match_o = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == MODE_OFF)
      AST_OFF_SILENT: assert (!match_o) else $error("disabled entry matched"); // R1
    if ((mode == MODE_TOR) && (own_reg_i <= prev_reg_i))
      AST_TOR_EMPTY: assert (!match_o) else $error("empty range matched"); // R2
    if ((mode == MODE_NAPOT) && (&own_reg_i))
      AST_NAPOT_FULL: assert (match_o) else $error("full region missed"); // R4
    if ((mode == MODE_NA4) && match_o)
      AST_NA4_ONE_WORD: assert (word_i == own_reg_i) else $error("single word mismatch"); // R3
  end

endmodule

// File: rtl/pmp_prio_sel.sv
module pmp_prio_sel #(
  parameter int unsigned NUM_ENTRIES = 8,
  localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [NUM_ENTRIES-1:0] hit_vec_i,
  output logic [NUM_ENTRIES-1:0] grant_o,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   any_o
);

  logic [NUM_ENTRIES-1:0] below_mask;

  always_comb begin
    grant_o     = '0;
    grant_idx_o = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec_i[i]) begin
        grant_o     = '0;
        grant_o[i]  = 1'b1;
        grant_idx_o = IDX_W'(i);
      end
    end
  end

  assign any_o      = |hit_vec_i;
  assign below_mask = grant_o - {{(NUM_ENTRIES-1){1'b0}}, 1'b1};

  always_comb begin
    AST_GRANT_ONEHOT: assert ($onehot0(grant_o)) else $error("grant not one-hot"); // R5
    if (any_o)
      AST_GRANT_LOWEST: assert (((hit_vec_i & below_mask) == '0) && ((grant_o & hit_vec_i) != '0))
        else $error("grant is not lowest hit"); // R5
  end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
#(
  parameter bit HAS_ENTRIES = 1'b1
) (
  input  logic      hit_any_i,
  input  logic      lock_i,
  input  logic      r_i,
  input  logic      w_i,
  input  logic      x_i,
  input  acc_kind_e kind_i,
  input  logic [1:0] priv_i,
  output logic      allow_o
);

  logic is_machine;
  logic perm_bit;
  logic enforce;
  logic miss_verdict;

  assign is_machine   = (priv_i == PRIV_MACHINE);
  assign perm_bit     = perm_for_kind(kind_i, r_i, w_i, x_i);
  assign enforce      = lock_i || !is_machine;
  assign miss_verdict = is_machine || !HAS_ENTRIES;

  always_comb begin
    if (!hit_any_i)
      allow_o = miss_verdict;
    else if (enforce)
      allow_o = perm_bit;
    else
      allow_o = 1'b1;
  end

  always_comb begin
    if (is_machine && (!hit_any_i || !lock_i))
      AST_MACHINE_PASS: assert (allow_o) else $error("machine access refused"); // R6
    if (hit_any_i && lock_i && !perm_bit)
      AST_LOCK_ENFORCED: assert (!allow_o) else $error("locked entry bypassed"); // R7
    if (hit_any_i && !is_machine)
      AST_LOWER_PRIV_CHECKED: assert (allow_o == perm_bit) else $error("lower privilege unchecked"); // R8
    if (HAS_ENTRIES && !hit_any_i && !is_machine)
      AST_MISS_FAULTS: assert (!allow_o) else $error("unmatched access allowed"); // R9
  end

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PA_W        = 34,
  localparam int unsigned WORD_W     = PA_W - 2,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [WORD_W-1:0]             pa_word_i,
  input  logic [1:0]                    acc_kind_i,
  input  logic [1:0]                    priv_i,
  input  logic [8*NUM_ENTRIES-1:0]      cfg_i,
  input  logic [WORD_W*NUM_ENTRIES-1:0] addr_reg_i,
  output logic                          allow_o
);

  entry_cfg_t             cfg_arr [NUM_ENTRIES];
  logic [WORD_W-1:0]      reg_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit_vec;
  logic [NUM_ENTRIES-1:0] grant_vec;
  logic [IDX_W-1:0]       grant_idx;
  logic                   hit_any;
  entry_cfg_t             sel_cfg;
  logic [2*NUM_ENTRIES-1:0] unused_rsvd_bits;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_unpack
    assign cfg_arr[g] = entry_cfg_t'(cfg_i[8*g +: 8]);
    assign reg_arr[g] = addr_reg_i[WORD_W*g +: WORD_W];
    assign unused_rsvd_bits[2*g +: 2] = cfg_arr[g].rsvd;
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
    logic [WORD_W-1:0] lower_bound;
    if (g == 0) begin : g_first
      assign lower_bound = '0;
    end else begin : g_rest
      assign lower_bound = reg_arr[g-1];
    end

    pmp_entry_match #(
      .WORD_W (WORD_W)
    ) u_match (
      .word_i     (pa_word_i),
      .mode_i     (cfg_arr[g].mode),
      .own_reg_i  (reg_arr[g]),
      .prev_reg_i (lower_bound),
      .match_o    (hit_vec[g])
    );
  end

  pmp_prio_sel #(
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_prio (
    .hit_vec_i   (hit_vec),
    .grant_o     (grant_vec),
    .grant_idx_o (grant_idx),
    .any_o       (hit_any)
  );

  assign sel_cfg = cfg_arr[grant_idx];

  pmp_perm_eval #(
    .HAS_ENTRIES (NUM_ENTRIES > 0)
  ) u_perm (
    .hit_any_i (hit_any),
    .lock_i    (sel_cfg.lock),
    .r_i       (sel_cfg.r),
    .w_i       (sel_cfg.w),
    .x_i       (sel_cfg.x),
    .kind_i    (acc_kind_e'(acc_kind_i)),
    .priv_i    (priv_i),
    .allow_o   (allow_o)
  );

  always_comb begin
    if (hit_any)
      AST_GRANT_MATCHES_IDX: assert (grant_vec[grant_idx]) else $error("index disagrees with grant"); // R5
    if ((priv_i == PRIV_MACHINE) && !hit_any)
      AST_TOP_MACHINE_MISS: assert (allow_o) else $error("machine miss refused"); // R9
  end

endmodule

// File: tb/pmp_access_checker_bench.sv
module pmp_access_checker_bench;

  localparam int N      = 8;
  localparam int PA_W   = 34;
  localparam int WORD_W = PA_W - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [WORD_W-1:0]   pa_word;
  logic [1:0]          acc_kind;
  logic [1:0]          priv;
  logic [8*N-1:0]      cfg_vec;
  logic [WORD_W*N-1:0] reg_vec;
  logic                allow;

  bit [7:0]        cfg_b  [N];
  bit [WORD_W-1:0] areg_b [N];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_vec[8*i +: 8]          = cfg_b[i];
      reg_vec[WORD_W*i +: WORD_W] = areg_b[i];
    end
  end

  pmp_access_checker #(.NUM_ENTRIES(N), .PA_W(PA_W)) u_pmp_access_checker (
    .pa_word_i  (pa_word),
    .acc_kind_i (acc_kind),
    .priv_i     (priv),
    .cfg_i      (cfg_vec),
    .addr_reg_i (reg_vec),
    .allow_o    (allow)
  );

  // Behavioural model: integer arithmetic, trailing ones counted by a loop.
  function automatic bit model_allow(longint w, int kind, int pv);
    for (int i = 0; i < N; i++) begin
      int     mode = int'(cfg_b[i][4:3]);
      longint hi   = longint'(areg_b[i]);
      longint lo   = (i == 0) ? 0 : longint'(areg_b[i-1]);
      bit     hit  = 0;
      if (mode == 1) hit = (w >= lo) && (w < hi);
      else if (mode == 2) hit = (w == hi);
      else if (mode == 3) begin
        int ones = 0;
        while (ones < WORD_W && areg_b[i][ones]) ones++;
        hit = ((w >> (ones + 1)) == (hi >> (ones + 1)));
      end
      if (hit) begin
        bit p;
        if (pv == 3 && !cfg_b[i][7]) return 1;
        if (kind == 0) p = cfg_b[i][2];
        else if (kind == 1) p = cfg_b[i][0];
        else p = cfg_b[i][1];
        return p;
      end
    end
    return (pv == 3);
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      cfg_b[i]  = 8'h00;
      areg_b[i] = '0;
    end
  endtask

  task automatic set_entry(int idx, bit [7:0] c, longint r);
    cfg_b[idx]  = c;
    areg_b[idx] = r[WORD_W-1:0];
  endtask

  // Drive after a falling edge; the verdict is combinational, sample 5 ns later.
  task automatic chk(longint byte_addr, int kind, int pv, bit exp, string tag);
    bit mdl;
    @(negedge clk);
    pa_word  = byte_addr[PA_W-1:2];
    acc_kind = kind[1:0];
    priv     = pv[1:0];
    #5;
    mdl = model_allow(byte_addr >> 2, kind, pv);
    checks++;
    if (allow !== exp || mdl !== exp) begin
      errors++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d actual=%b expected=%b model=%b",
               tag, byte_addr, kind, pv, allow, exp, mdl);
    end
  endtask

  task automatic chk_model(longint byte_addr, int kind, int pv, string tag);
    chk(byte_addr, kind, pv, model_allow(byte_addr >> 2, kind, pv), tag);
  endtask

  initial begin
    int limit = 200000;
    repeat (limit) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pa_word = '0; acc_kind = '0; priv = '0;
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset state: every entry off.
    chk(64'h1000, 1, 0, 0, "R9 no entry user load");
    chk(64'h1000, 2, 3, 1, "R9 no entry machine store");
    chk(64'h1000, 1, 1, 0, "R9 no entry supervisor load");

    // R1: disabled entry ignored even with a register pointing at the word.
    set_entry(0, 8'h07, 64'h400);
    chk(64'h1000, 1, 0, 0, "R1 off entry ignored");

    // R2: range on entry 1, lower bound from entry 0 register.
    clear_all();
    set_entry(0, 8'h00, 64'h400);
    set_entry(1, 8'h09, 64'h800);
    chk(64'h1000, 1, 0, 1, "R2 range low edge");
    chk(64'h1FFC, 1, 0, 1, "R2 range top word");
    chk(64'h0FFC, 1, 0, 0, "R2 below range");
    chk(64'h2000, 1, 0, 0, "R2 upper exclusive");
    clear_all();
    set_entry(0, 8'h09, 64'h400);
    chk(64'h0000, 1, 0, 1, "R2 entry0 lower is zero");
    chk(64'h1000, 1, 0, 0, "R2 entry0 upper exclusive");
    set_entry(0, 8'h09, 64'h0);
    chk(64'h0000, 1, 0, 0, "R2 empty range");

    // R3: single word.
    clear_all();
    set_entry(2, 8'h11, 64'h1000);
    chk(64'h4000, 1, 0, 1, "R3 word hit");
    chk(64'h4004, 1, 0, 0, "R3 next word");
    chk(64'h3FFC, 1, 0, 0, "R3 previous word");

    // R4: power-of-two regions.
    clear_all();
    set_entry(3, 8'h19, 64'h2007);
    chk(64'h8000, 1, 1, 1, "R4 64B base");
    chk(64'h803C, 1, 1, 1, "R4 64B last word");
    chk(64'h8040, 1, 1, 0, "R4 64B past end");
    chk(64'h7FFC, 1, 1, 0, "R4 64B before base");
    set_entry(3, 8'h19, 64'h2010);
    chk(64'h8044, 1, 1, 1, "R4 8B second word");
    chk(64'h8048, 1, 1, 0, "R4 8B past end");
    set_entry(3, 8'h19, 64'hFFFF_FFFF);
    chk(64'h3_0000_0000, 1, 1, 1, "R4 all ones matches all");

    // R5: lowest index wins.
    clear_all();
    set_entry(0, 8'h10, 64'h500);
    set_entry(1, 8'h11, 64'h500);
    chk(64'h1400, 1, 0, 0, "R5 lower entry denies");
    set_entry(0, 8'h11, 64'h500);
    set_entry(1, 8'h10, 64'h500);
    chk(64'h1400, 1, 0, 1, "R5 lower entry grants");

    // R6 / R7: machine handling.
    clear_all();
    set_entry(0, 8'h10, 64'h500);
    chk(64'h1400, 2, 3, 1, "R6 unlocked machine store");
    chk(64'h1400, 0, 3, 1, "R6 unlocked machine fetch");
    set_entry(0, 8'h90, 64'h500);
    chk(64'h1400, 2, 3, 0, "R7 locked machine store");
    set_entry(0, 8'h93, 64'h500);
    chk(64'h1400, 2, 3, 1, "R7 locked machine store W");
    chk(64'h1400, 0, 3, 0, "R7 locked machine fetch no X");

    // R8: kind selects the permission bit.
    clear_all();
    set_entry(0, 8'h14, 64'h500);
    chk(64'h1400, 0, 0, 1, "R8 fetch X");
    chk(64'h1400, 1, 0, 0, "R8 load no R");
    chk(64'h1400, 2, 1, 0, "R8 store no W");
    set_entry(0, 8'h13, 64'h500);
    chk(64'h1400, 2, 1, 1, "R8 store W");
    chk(64'h1400, 3, 0, 1, "R8 atomic W");
    chk(64'h1400, 0, 1, 0, "R8 fetch no X");

    // R10: reserved bits have no effect.
    set_entry(0, 8'h73, 64'h500);
    chk(64'h1400, 2, 0, 1, "R10 reserved set");
    chk(64'h1400, 0, 0, 0, "R10 reserved set fetch");

    // Random mix: priority, locking, modes together.
    for (int n = 0; n < 3000; n++) begin
      int pv_sel = $urandom_range(0, 2);
      for (int i = 0; i < N; i++) begin
        bit [7:0] c = 8'($urandom);
        c[7] = ($urandom_range(0, 7) == 0);
        set_entry(i, c, longint'($urandom_range(0, 16'h120)));
      end
      chk_model(longint'($urandom_range(0, 16'h130)) << 2, $urandom_range(0, 3),
                (pv_sel == 2) ? 3 : pv_sel, "R5 random mix");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule